// File: doc/BRIEF.md
# PCI Target Command to Local Transaction Mapper

This block sits behind the target side of a PCI interface. It takes one PCI target command that has already been decoded, along with two other inputs: whether the addressed window is prefetchable, and how many words the write FIFO holds. From these it forms one local-bus transaction request. The request states whether it is a read or a write, whether it is a single transfer or a burst, which byte enables it uses, and how long it is.

If the block cannot serve a command, it raises a one-cycle unsupported flag and issues no request. Otherwise a small controller holds the request until the local bus acknowledges it. It then signals completion for one cycle and returns to idle. PCI signalling, the data FIFOs and the local bus itself lie outside this block.

Top module: `pci_cmd_mapper`

## Requirements
- R1: While reset is active, and in the first cycle after it, `req_o`, `done_o` and `unsup_o` are low.
- R2: A command with code 0x2 or 0x3 (I/O), or any code other than 0x6, 0x7, 0xC, 0xE or 0xF, sets `unsup_o` high for exactly the cycle after the command is accepted, and no request is raised.
- R3: Any command, including a supported code, gives the unsupported pulse and no request when `prefetch_i` is low.
- R4: Codes 0x6 and 0xE each give a single read: `req_write_o`=0, `req_burst_o`=0, `req_len_o`=1, and `req_be_o` equal to `be_i`.
- R5: Code 0xC gives a burst read of `RD_BURST` words with every byte enable set.
- R6: Code 0x7 with a FIFO level of 0 or 1 gives a single write with `req_len_o`=1 that keeps `be_i`.
- R7: Code 0x7 with a FIFO level of 2 or more gives a burst write with every byte enable set. Its length is the FIFO level, capped at `MAX_BURST`.
- R8: Code 0xF gives a burst write with every byte enable set. Its length is the FIFO level limited to the range 2 to `MAX_BURST`.
- R9: `req_o` rises in the cycle after an accepted command. It stays high with all request fields unchanged until `req_ack_i` is seen high at a clock edge. In the next cycle `done_o` is high for one cycle and `req_o` is low. The cycle after that is idle.
- R10: `cmd_valid_i` is ignored while a request is pending or completing.
- R11: `req_ack_i` has no effect outside a pending request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command present this cycle |
| cmd_i | input | 4 | PCI command code |
| prefetch_i | input | 1 | Addressed window is prefetchable |
| wr_level_i | input | LVL_W | Words held in the write FIFO |
| be_i | input | BE_W | Byte enables of the PCI data phase |
| req_ack_i | input | 1 | Local bus accepted the request |
| req_o | output | 1 | Request pending |
| req_write_o | output | 1 | 1 = write, 0 = read |
| req_burst_o | output | 1 | 1 = burst, 0 = single |
| req_be_o | output | BE_W | Byte enables of the request |
| req_len_o | output | LEN_W | Transfer length in words |
| done_o | output | 1 | One-cycle completion pulse |
| unsup_o | output | 1 | One-cycle unsupported command pulse |

## Verification
A controller stuck in the pending state shows up as `req_o` that never falls after an acknowledge. A controller that falls out of that state early shows up as `done_o` with no acknowledge, one cycle after the fault. Request fields that are corrupted while waiting change value at the ports in the very next cycle. A wrong classification appears in the first cycle after the command, either as the wrong type or length or as a missing or spurious unsupported pulse. The directed scenarios cover each command code, both window types, and FIFO levels at 0, 1, inside the range and above the cap.

// File: rtl/pcm_pkg.sv
package pcm_pkg;
  typedef enum logic [3:0] {
    CMD_IO_RD   = 4'h2,
    CMD_IO_WR   = 4'h3,
    CMD_MEM_RD  = 4'h6,
    CMD_MEM_WR  = 4'h7,
    CMD_RD_MULT = 4'hC,
    CMD_RD_LINE = 4'hE,
    CMD_WR_INV  = 4'hF
  } pci_cmd_e;

  typedef enum logic [2:0] {
    K_NONE,
    K_SRD,
    K_BRD,
    K_SWR,
    K_BWR,
    K_BWR_INV
  } xact_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_DONE  = 2'd2
  } fsm_state_e;
endpackage

// File: rtl/pcm_classify.sv
module pcm_classify
  import pcm_pkg::*;
#(
  parameter int LVL_W = 6
) (
  input  logic [3:0]       cmd_i,
  input  logic             prefetch_i,
  input  logic [LVL_W-1:0] wr_level_i,
  output xact_kind_e       kind_o
);
  logic multi_words;
  assign multi_words = (wr_level_i >= LVL_W'(2));

  always_comb begin
    kind_o = K_NONE;
    if (prefetch_i) begin
      unique case (cmd_i)
        CMD_MEM_RD,
        CMD_RD_LINE: kind_o = K_SRD;
        CMD_RD_MULT: kind_o = K_BRD;
        CMD_MEM_WR:  kind_o = multi_words ? K_BWR : K_SWR;
        CMD_WR_INV:  kind_o = K_BWR_INV;
        default:     kind_o = K_NONE;
      endcase
    end
  end
endmodule

// File: rtl/pcm_len_sel.sv
module pcm_len_sel
  import pcm_pkg::*;
#(
  parameter int LVL_W     = 6,
  parameter int MAX_BURST = 16,
  parameter int RD_BURST  = 8,
  parameter int LEN_W     = $clog2(MAX_BURST + 1)
) (
  input  xact_kind_e       kind_i,
  input  logic [LVL_W-1:0] wr_level_i,
  output logic [LEN_W-1:0] len_o
);
  localparam logic [LVL_W-1:0] LvlMax = LVL_W'(MAX_BURST);

  logic [LEN_W-1:0] clamped;

  always_comb begin
    if (wr_level_i > LvlMax)            clamped = LEN_W'(MAX_BURST);
    else if (wr_level_i < LVL_W'(2))    clamped = LEN_W'(2);
    else                                clamped = LEN_W'(wr_level_i);
  end

  always_comb begin
    unique case (kind_i)
      K_BRD:            len_o = LEN_W'(RD_BURST);
      K_BWR, K_BWR_INV: len_o = clamped;
      default:          len_o = LEN_W'(1);
    endcase
  end
endmodule

// File: rtl/pcm_fsm.sv
module pcm_fsm
  import pcm_pkg::*;
#(
  parameter int BE_W  = 4,
  parameter int LEN_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_valid_i,
  input  xact_kind_e       kind_i,
  input  logic [BE_W-1:0]  be_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             req_ack_i,
  output logic             req_o,
  output logic             req_write_o,
  output logic             req_burst_o,
  output logic [BE_W-1:0]  req_be_o,
  output logic [LEN_W-1:0] req_len_o,
  output logic             done_o,
  output logic             unsup_o
);
  fsm_state_e       state_q, state_d;
  logic             write_q, burst_q, unsup_q;
  logic [BE_W-1:0]  be_q;
  logic [LEN_W-1:0] len_q;
  logic             accept, is_burst, is_write;

  assign accept   = (state_q == ST_IDLE) && cmd_valid_i;
  assign is_burst = (kind_i == K_BRD) || (kind_i == K_BWR) || (kind_i == K_BWR_INV);
  assign is_write = (kind_i == K_SWR) || (kind_i == K_BWR) || (kind_i == K_BWR_INV);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (accept && kind_i != K_NONE) state_d = ST_ISSUE;
      ST_ISSUE: if (req_ack_i) state_d = ST_DONE;
      ST_DONE:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      write_q <= 1'b0;
      burst_q <= 1'b0;
      be_q    <= '0;
      len_q   <= '0;
      unsup_q <= 1'b0;
    end else begin
      state_q <= state_d;
      unsup_q <= accept && (kind_i == K_NONE);
      if (accept && kind_i != K_NONE) begin
        write_q <= is_write;
        burst_q <= is_burst;
        be_q    <= is_burst ? {BE_W{1'b1}} : be_i;
        len_q   <= len_i;
      end
    end
  end

  assign req_o       = (state_q == ST_ISSUE);
  assign done_o      = (state_q == ST_DONE);
  assign unsup_o     = unsup_q;
  assign req_write_o = write_q;
  assign req_burst_o = burst_q;
  assign req_be_o    = be_q;
  assign req_len_o   = len_q;
endmodule

// File: rtl/pci_cmd_mapper.sv
module pci_cmd_mapper
  import pcm_pkg::*;
#(
  parameter int BE_W      = 4,
  parameter int LVL_W     = 6,
  parameter int MAX_BURST = 16,
  parameter int RD_BURST  = 8,
  parameter int LEN_W     = $clog2(MAX_BURST + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_valid_i,
  input  logic [3:0]       cmd_i,
  input  logic             prefetch_i,
  input  logic [LVL_W-1:0] wr_level_i,
  input  logic [BE_W-1:0]  be_i,
  input  logic             req_ack_i,
  output logic             req_o,
  output logic             req_write_o,
  output logic             req_burst_o,
  output logic [BE_W-1:0]  req_be_o,
  output logic [LEN_W-1:0] req_len_o,
  output logic             done_o,
  output logic             unsup_o
);
  xact_kind_e       kind;
  logic [LEN_W-1:0] len;

  pcm_classify #(.LVL_W(LVL_W)) i_classify (
    .cmd_i      (cmd_i),
    .prefetch_i (prefetch_i),
    .wr_level_i (wr_level_i),
    .kind_o     (kind)
  );

  pcm_len_sel #(
    .LVL_W(LVL_W), .MAX_BURST(MAX_BURST), .RD_BURST(RD_BURST), .LEN_W(LEN_W)
  ) i_len_sel (
    .kind_i     (kind),
    .wr_level_i (wr_level_i),
    .len_o      (len)
  );

  pcm_fsm #(.BE_W(BE_W), .LEN_W(LEN_W)) i_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmd_valid_i (cmd_valid_i),
    .kind_i      (kind),
    .be_i        (be_i),
    .len_i       (len),
    .req_ack_i   (req_ack_i),
    .req_o       (req_o),
    .req_write_o (req_write_o),
    .req_burst_o (req_burst_o),
    .req_be_o    (req_be_o),
    .req_len_o   (req_len_o),
    .done_o      (done_o),
    .unsup_o     (unsup_o)
  );
endmodule

// File: rtl/pcm_checker.sv
module pcm_checker #(
  parameter int BE_W      = 4,
  parameter int LVL_W     = 6,
  parameter int MAX_BURST = 16,
  parameter int LEN_W     = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cmd_valid_i,
  input logic             prefetch_i,
  input logic             req_ack_i,
  input logic             req_o,
  input logic             req_write_o,
  input logic             req_burst_o,
  input logic [BE_W-1:0]  req_be_o,
  input logic [LEN_W-1:0] req_len_o,
  input logic             done_o,
  input logic             unsup_o
);
  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o && !req_ack_i |=> req_o && $stable(req_write_o) && $stable(req_burst_o)
                            && $stable(req_be_o) && $stable(req_len_o));

  p_ack_done_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o && req_ack_i |=> done_o && !req_o);

  p_done_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && !req_o);

  p_done_cause_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(req_o) && $past(req_ack_i));

  p_burst_be_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o && req_burst_o |-> req_be_o == {BE_W{1'b1}});

  p_burst_len_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o && req_burst_o |-> req_len_o >= LEN_W'(2) && req_len_o <= LEN_W'(MAX_BURST));

  p_single_len_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o && !req_burst_o |-> req_len_o == LEN_W'(1));

  p_unsup_excl_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unsup_o |-> !req_o && !done_o && $past(cmd_valid_i));

  p_nonpref_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_o) |-> $past(prefetch_i) && $past(cmd_valid_i));

  p_one_state_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({req_o, done_o, unsup_o}));
endmodule

bind pci_cmd_mapper pcm_checker #(
  .BE_W(BE_W), .LVL_W(LVL_W), .MAX_BURST(MAX_BURST), .LEN_W(LEN_W)
) i_pcm_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cmd_valid_i (cmd_valid_i),
  .prefetch_i  (prefetch_i),
  .req_ack_i   (req_ack_i),
  .req_o       (req_o),
  .req_write_o (req_write_o),
  .req_burst_o (req_burst_o),
  .req_be_o    (req_be_o),
  .req_len_o   (req_len_o),
  .done_o      (done_o),
  .unsup_o     (unsup_o)
);

// File: tb/test_pci_cmd_mapper.sv
module test_pci_cmd_mapper;
  localparam int BE_W = 4, LVL_W = 6, MAX_BURST = 16, RD_BURST = 8;
  localparam int LEN_W = $clog2(MAX_BURST + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, prefetch = 1'b0, ack = 1'b0;
  logic [3:0] cmd = '0;
  logic [LVL_W-1:0] level = '0;
  logic [BE_W-1:0] be = '0;
  logic req, req_wr, req_burst, done, unsup;
  logic [BE_W-1:0] req_be;
  logic [LEN_W-1:0] req_len;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  pci_cmd_mapper #(.BE_W(BE_W), .LVL_W(LVL_W), .MAX_BURST(MAX_BURST), .RD_BURST(RD_BURST))
  i_pci_cmd_mapper (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_i(cmd),
    .prefetch_i(prefetch), .wr_level_i(level), .be_i(be), .req_ack_i(ack),
    .req_o(req), .req_write_o(req_wr), .req_burst_o(req_burst), .req_be_o(req_be),
    .req_len_o(req_len), .done_o(done), .unsup_o(unsup));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // drive one command for one cycle; returns at the negedge after acceptance
  task automatic send(input logic [3:0] c, input logic pf, input int lvl, input logic [3:0] b);
    @(negedge clk);
    cmd = c; prefetch = pf; level = LVL_W'(lvl); be = b; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic finish_req(input string tag);
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
    chk({tag, " done"}, done, 1);
    chk({tag, " req low"}, req, 0);
    @(negedge clk);
    chk({tag, " done pulse"}, done, 0);
  endtask

  task automatic expect_req(input string tag, input int wr, input int bu, input int b, input int len);
    chk({tag, " req"}, req, 1);
    chk({tag, " write"}, req_wr, wr);
    chk({tag, " burst"}, req_burst, bu);
    chk({tag, " be"}, req_be, b);
    chk({tag, " len"}, req_len, len);
    chk({tag, " unsup"}, unsup, 0);
    finish_req(tag);
  endtask

  task automatic expect_unsup(input string tag);
    chk({tag, " unsup"}, unsup, 1);
    chk({tag, " req"}, req, 0);
    @(negedge clk);
    chk({tag, " unsup pulse"}, unsup, 0);
    chk({tag, " req stays"}, req, 0);
  endtask

  task automatic t_reset;
    chk("R1 req in reset", req, 0);
    chk("R1 done in reset", done, 0);
    chk("R1 unsup in reset", unsup, 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R1 req after reset", req, 0);
    chk("R1 unsup after reset", unsup, 0);
  endtask

  task automatic t_unsup_codes;
    send(4'h2, 1'b1, 3, 4'h5); expect_unsup("R2 io read");
    send(4'h3, 1'b1, 3, 4'h5); expect_unsup("R2 io write");
    send(4'h0, 1'b1, 3, 4'h5); expect_unsup("R2 code 0");
    send(4'hA, 1'b1, 3, 4'h5); expect_unsup("R2 code A");
  endtask

  task automatic t_nonpref;
    send(4'h6, 1'b0, 3, 4'h5); expect_unsup("R3 read nonpref");
    send(4'hF, 1'b0, 8, 4'h5); expect_unsup("R3 inval nonpref");
    send(4'h7, 1'b0, 1, 4'h5); expect_unsup("R3 write nonpref");
  endtask

  task automatic t_single_read;
    send(4'h6, 1'b1, 0, 4'h9); expect_req("R4 mem read", 0, 0, 9, 1);
    send(4'hE, 1'b1, 7, 4'h3); expect_req("R4 read line", 0, 0, 3, 1);
  endtask

  task automatic t_burst_read;
    send(4'hC, 1'b1, 0, 4'h1); expect_req("R5 read mult", 0, 1, 15, RD_BURST);
  endtask

  task automatic t_write;
    send(4'h7, 1'b1, 1, 4'h6); expect_req("R6 write lvl1", 1, 0, 6, 1);
    send(4'h7, 1'b1, 0, 4'h2); expect_req("R6 write lvl0", 1, 0, 2, 1);
    send(4'h7, 1'b1, 2, 4'h2); expect_req("R7 write lvl2", 1, 1, 15, 2);
    send(4'h7, 1'b1, 5, 4'h2); expect_req("R7 write lvl5", 1, 1, 15, 5);
    send(4'h7, 1'b1, 40, 4'h2); expect_req("R7 write cap", 1, 1, 15, MAX_BURST);
  endtask

  task automatic t_invalidate;
    send(4'hF, 1'b1, 0, 4'h4); expect_req("R8 inval lvl0", 1, 1, 15, 2);
    send(4'hF, 1'b1, 9, 4'h4); expect_req("R8 inval lvl9", 1, 1, 15, 9);
    send(4'hF, 1'b1, 16, 4'h4); expect_req("R8 inval lvl16", 1, 1, 15, MAX_BURST);
    send(4'hF, 1'b1, 63, 4'h4); expect_req("R8 inval cap", 1, 1, 15, MAX_BURST);
  endtask

  task automatic t_hold_ignore;
    send(4'h6, 1'b1, 0, 4'hA);
    cmd = 4'hC; level = 6'd12; be = 4'h1; cmd_valid = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R9 req held", req, 1);
      chk("R10 burst unchanged", req_burst, 0);
      chk("R10 be unchanged", req_be, 10);
      chk("R10 len unchanged", req_len, 1);
      chk("R9 no early done", done, 0);
    end
    cmd = 4'h2;
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
    chk("R9 done after ack", done, 1);
    chk("R10 no unsup while busy", unsup, 0);
    cmd = 4'h6;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R10 cmd in done ignored", req, 0);
    chk("R10 no unsup from done", unsup, 0);
    chk("R9 done one cycle", done, 0);
  endtask

  task automatic t_stray_ack;
    @(negedge clk); ack = 1'b1;
    @(negedge clk); ack = 1'b0;
    chk("R11 stray ack req", req, 0);
    chk("R11 stray ack done", done, 0);
    @(negedge clk);
    chk("R11 stray ack done later", done, 0);
    send(4'hC, 1'b1, 0, 4'h0); expect_req("R11 after stray ack", 0, 1, 15, RD_BURST);
  endtask

  initial begin
    t_reset();
    t_unsup_codes();
    t_nonpref();
    t_single_read();
    t_burst_read();
    t_write();
    t_invalidate();
    t_hold_ignore();
    t_stray_ack();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule